// File: doc/BRIEF.md
# Parallel EEPROM Write-Cycle Sequencer

This block is a clocked model of the internal write control in a byte-wide parallel EEPROM. It brings the asynchronous chip-enable, output-enable and write-enable strobes (all active low) into the clock domain. It captures write bytes into a page buffer. An inter-byte load timer closes the page, and a timed programming phase then copies the page into a register-file array.

While a write cycle is in progress, reads do not return array data. They return a status byte instead:
- Bit 7 is the complement of bit 7 of the most recently accepted byte.
- Bit 6 flips after each read.
- Bit 5 shows whether the load timer has expired.
- The low five bits are left undriven.

A separate output requests an open-drain busy pull-down while programming runs. All durations are parameters counted in clock cycles, so a bench can use short values.

Top module: `eeprom_write_seq`

## Requirements
- R1: A write is recognised only while chip enable and write enable are both low with output enable high. A strobe with output enable low stores nothing.
- R2: The write address is taken when the write condition becomes true, and the write data when it ends. Address changes later in the strobe and data values before its end have no effect.
- R3: A page holds up to 32 bytes that share address bits above bit 4. While a page is loading, a write to a different page is ignored.
- R4: Each accepted byte restarts a load window of LOAD_WIN_CYC cycles. A byte that arrives inside the window joins the page. When the window expires, programming starts.
- R5: Programming lasts PROG_CYC cycles. During it `busy_drive_low` is 1, and it returns to 0 at the end. The array shows the new page contents only after programming completes.
- R6: From the first accepted byte until programming ends, a read returns on `dout[7]` the inverse of bit 7 of the last accepted byte. Afterwards the true stored value is read.
- R7: During the same period, `dout[6]` is 0 on the first read and inverts after every read. Once programming ends, reads return array data and no longer toggle.
- R8: `dout[5]` reads 0 while the load window runs and 1 while programming. Writes during programming are ignored.
- R9: For PWR_WR_CYC cycles after reset, writes are ignored. For PWR_RD_CYC cycles after reset, reads leave `dout_oe` at 0.
- R10: A status read drives only bits 7..5 (`dout_oe` = 8'hE0). An idle read drives all bits (`dout_oe` = 8'hFF) with the array byte at `addr`.
- R11: After reset every array byte reads 8'hFF, `busy_drive_low` is 0 and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, also the power-up reference |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 8 | Per-bit output drive enable; 0 means high impedance |
| busy_drive_low | output | 1 | 1 while programming: the open-drain busy line is pulled low |

## Verification
The bench builds the block with LOAD_WIN_CYC = 40, PROG_CYC = 200, PWR_WR_CYC = 300 and PWR_RD_CYC = 20. These values are far below the real-time defaults, which lets a run cover every phase of the sequence: the power-up write lockout, a 32-byte page load, a load window that expires and one that is kept open, and reads taken during both loading and programming. Strobes last several clock cycles, so each synchroniser delay settles before the bench samples an output.

// File: rtl/eews_pkg.sv
package eews_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;

  // Bits of the status byte that are driven; the rest float.
  localparam logic [7:0] STATUS_DRIVE = 8'b1110_0000;

  function automatic logic [7:0] status_byte(input logic last_msb,
                                             input logic tog,
                                             input logic timed_out);
    return {~last_msb, tog, timed_out, 5'b0_0000};
  endfunction

  function automatic logic at_last_count(input logic [31:0] cnt,
                                         input logic [31:0] limit);
    return cnt == limit - 32'd1;
  endfunction

endpackage

// File: rtl/eews_sync.sv
module eews_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= 2'b11;
        else        stg <= {stg[0], async_in[i]};
      end
      assign sync_out[i] = stg[1];
    end
  endgenerate

endmodule

// File: rtl/eews_seq_ctrl.sv
module eews_seq_ctrl
  import eews_pkg::*;
#(
  parameter int PAGE_W       = 5,
  parameter int LOAD_WIN_CYC = 5000,
  parameter int PROG_CYC     = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic              rd_end,
  input  logic              wr_ok,
  input  logic [PAGE_W-1:0] cap_page,
  input  logic [7:0]        wr_data,
  output seq_state_t        state,
  output logic              byte_accept,
  output logic              load_expire,
  output logic              prog_done,
  output logic              toggle,
  output logic              last_msb,
  output logic [PAGE_W-1:0] page_addr
);

  localparam int LW = $clog2(LOAD_WIN_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [LW-1:0] load_cnt;
  logic [PW-1:0] prog_cnt;
  logic          page_match;

  assign page_match  = (cap_page == page_addr);
  assign load_expire = (state == ST_LOAD) &&
                       at_last_count(32'(load_cnt), 32'(LOAD_WIN_CYC));
  assign prog_done   = (state == ST_PROG) &&
                       at_last_count(32'(prog_cnt), 32'(PROG_CYC));
  assign byte_accept = wr_end && wr_ok &&
                       ((state == ST_IDLE) ||
                        ((state == ST_LOAD) && page_match && !load_expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      load_cnt  <= '0;
      prog_cnt  <= '0;
      toggle    <= 1'b0;
      last_msb  <= 1'b0;
      page_addr <= '0;
    end else begin
      if (byte_accept) begin
        load_cnt <= '0;
        last_msb <= wr_data[7];
        if (state == ST_IDLE) begin
          page_addr <= cap_page;
          state     <= ST_LOAD;
        end
      end else if (load_expire) begin
        state    <= ST_PROG;
        prog_cnt <= '0;
      end else if (state == ST_LOAD) begin
        load_cnt <= load_cnt + 1'b1;
      end

      if (prog_done)              state    <= ST_IDLE;
      else if (state == ST_PROG)  prog_cnt <= prog_cnt + 1'b1;

      if (prog_done)                          toggle <= 1'b0;
      else if ((state != ST_IDLE) && rd_end)  toggle <= ~toggle;
    end
  end

  assert_accept_after_pwrup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |-> wr_ok);
  assert_no_accept_in_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> !byte_accept);
  assert_expire_starts_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_expire |=> (state == ST_PROG));
  assert_done_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (state == ST_IDLE));
  assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_IDLE) && rd_end && !prog_done) |=> (toggle != $past(toggle)));

endmodule

// File: rtl/eews_page_buf.sv
module eews_page_buf #(
  parameter int OFS_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          byte_accept,
  input  logic [OFS_W-1:0]              ofs,
  input  logic [7:0]                    wr_data,
  input  logic                          clear,
  output logic [(1<<OFS_W)-1:0][7:0]    pg_data,
  output logic [(1<<OFS_W)-1:0]         pg_valid
);

  localparam int PAGE_BYTES = 1 << OFS_W;

  generate
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pg_data[i]  <= 8'h00;
          pg_valid[i] <= 1'b0;
        end else if (clear) begin
          pg_valid[i] <= 1'b0;
        end else if (byte_accept && (ofs == OFS_W'(i))) begin
          pg_data[i]  <= wr_data;
          pg_valid[i] <= 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/eews_array.sv
module eews_array #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [ADDR_W-OFS_W-1:0]          page_addr,
  input  logic [(1<<OFS_W)-1:0][7:0]       pg_data,
  input  logic [(1<<OFS_W)-1:0]            pg_valid,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [7:0]                       rd_data
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pg_valid[i]) mem[{page_addr, OFS_W'(i)}] <= pg_data[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  assert_commit_has_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pg_valid != '0));

endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq
  import eews_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int OFS_W        = 5,
  parameter int LOAD_WIN_CYC = 5000,
  parameter int PROG_CYC     = 250000,
  parameter int PWR_WR_CYC   = 500000,
  parameter int PWR_RD_CYC   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic [7:0]        dout_oe,
  output logic              busy_drive_low
);

  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PWR_W      = $clog2(PWR_WR_CYC + 1);

  logic [2:0] strb_s;
  logic       ce_s, oe_s, we_s;
  logic       wr_lvl, rd_lvl, wr_lvl_q, rd_lvl_q;
  logic       wr_start, wr_end, rd_end;
  logic [PWR_W-1:0]  pwr_cnt;
  logic       wr_ok, rd_ok;
  logic [ADDR_W-1:0] cap_addr;

  seq_state_t        state;
  logic              byte_accept, load_expire, prog_done, toggle, last_msb;
  logic [PAGE_W-1:0] page_addr;
  logic [PAGE_BYTES-1:0][7:0] pg_data;
  logic [PAGE_BYTES-1:0]      pg_valid;
  logic [7:0]        arr_rd;

  eews_sync #(.WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ce_n, oe_n, we_n}),
    .sync_out(strb_s)
  );
  assign ce_s = strb_s[2];
  assign oe_s = strb_s[1];
  assign we_s = strb_s[0];

  assign wr_lvl   = !ce_s && !we_s && oe_s;
  assign rd_lvl   = !ce_s && !oe_s && we_s;
  assign wr_start = wr_lvl && !wr_lvl_q;
  assign wr_end   = !wr_lvl && wr_lvl_q;
  assign rd_end   = !rd_lvl && rd_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lvl_q <= 1'b0;
      rd_lvl_q <= 1'b0;
      pwr_cnt  <= '0;
      cap_addr <= '0;
    end else begin
      wr_lvl_q <= wr_lvl;
      rd_lvl_q <= rd_lvl;
      if (!wr_ok)   pwr_cnt  <= pwr_cnt + 1'b1;
      if (wr_start) cap_addr <= addr;
    end
  end

  assign wr_ok = (32'(pwr_cnt) >= 32'(PWR_WR_CYC));
  assign rd_ok = (32'(pwr_cnt) >= 32'(PWR_RD_CYC));

  eews_seq_ctrl #(
    .PAGE_W(PAGE_W), .LOAD_WIN_CYC(LOAD_WIN_CYC), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_end(wr_end), .rd_end(rd_end), .wr_ok(wr_ok),
    .cap_page(cap_addr[ADDR_W-1:OFS_W]), .wr_data(din),
    .state(state), .byte_accept(byte_accept), .load_expire(load_expire),
    .prog_done(prog_done), .toggle(toggle), .last_msb(last_msb),
    .page_addr(page_addr)
  );

  eews_page_buf #(.OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .byte_accept(byte_accept), .ofs(cap_addr[OFS_W-1:0]), .wr_data(din),
    .clear(prog_done), .pg_data(pg_data), .pg_valid(pg_valid)
  );

  eews_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .commit(prog_done), .page_addr(page_addr),
    .pg_data(pg_data), .pg_valid(pg_valid),
    .rd_addr(addr), .rd_data(arr_rd)
  );

  always_comb begin
    dout    = 8'h00;
    dout_oe = 8'h00;
    if (rd_lvl && rd_ok) begin
      if (state != ST_IDLE) begin
        dout    = status_byte(last_msb, toggle, state == ST_PROG);
        dout_oe = STATUS_DRIVE;
      end else begin
        dout    = arr_rd;
        dout_oe = 8'hFF;
      end
    end
  end

  assign busy_drive_low = (state == ST_PROG);

  assert_busy_only_when_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drive_low |-> (pg_valid != '0));
  assert_no_read_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |-> (dout_oe == 8'h00));

endmodule

// File: tb/tb_eeprom_write_seq.sv
module tb_eeprom_write_seq;

  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, dout_oe;
  logic busy_drive_low;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  eeprom_write_seq #(
    .ADDR_W(AW), .OFS_W(5), .LOAD_WIN_CYC(40), .PROG_CYC(200),
    .PWR_WR_CYC(300), .PWR_RD_CYC(20)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .busy_drive_low(busy_drive_low)
  );

  // Monitor: pops observed reads and compares them with the expectations.
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: dout/oe actual %h/%h expected %h/%h",
                 t, a[15:8], a[7:0], e[15:8], e[7:0]);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Address and data both change part-way through the strobe.
  task automatic wr_shift(input logic [AW-1:0] a, input logic [7:0] d_early,
                          input logic [AW-1:0] a_late, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d_early; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk);
    addr = a_late; din = d;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Driver: pushes the expected read, drives the read, hands the sample to the monitor.
  task automatic rd(input logic [AW-1:0] a, input logic [7:0] ed,
                    input logic [7:0] eoe, input string tag);
    exp_q.push_back({ed, eoe});
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    act_q.push_back({dout, dout_oe});
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_busy(input logic e, input string tag);
    @(negedge clk);
    n_tests++;
    if (busy_drive_low !== e) begin
      n_fail++;
      $display("FAIL %s: busy_drive_low actual %b expected %b", tag, busy_drive_low, e);
    end
  endtask

  function automatic logic [7:0] stat(input logic [7:0] last, input logic tg, input logic tmo);
    logic [7:0] s;
    s = 8'h00;
    s[7] = !last[7];
    s[6] = tg;
    s[5] = tmo;
    return s;
  endfunction

  function automatic logic [7:0] pg_val(input int i);
    return 8'(i * 7 + 3);
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk_busy(1'b0, "R11 busy after reset");
    n_tests++;
    if (dout_oe !== 8'h00) begin
      n_fail++;
      $display("FAIL R11 oe after reset: actual %h expected 00", dout_oe);
    end
    // R9 read before read-ready time stays undriven
    rd(10'h000, 8'h00, 8'h00, "R9 early read hi-Z");
    // R9 write before write-ready time is dropped
    wr(10'h005, 8'h3C, 1'b1);
    repeat (320) @(negedge clk);
    rd(10'h005, 8'hFF, 8'hFF, "R9 early write ignored / R11 erased");
    chk_busy(1'b0, "R9 no programming from early write");
    // R1 strobe with output enable low stores nothing
    wr(10'h010, 8'h5A, 1'b0);
    repeat (300) @(negedge clk);
    rd(10'h010, 8'hFF, 8'hFF, "R1 write with oe low ignored");

    // Single byte: status during load and programming
    wr(10'h021, 8'hA5, 1'b1);
    rd(10'h021, stat(8'hA5, 1'b0, 1'b0), 8'hE0, "R6 R8 R10 first status read in load");
    repeat (40) @(negedge clk);
    rd(10'h021, stat(8'hA5, 1'b1, 1'b1), 8'hE0, "R7 R8 second read toggles, timed out");
    wr(10'h022, 8'h11, 1'b1);
    rd(10'h300, stat(8'hA5, 1'b0, 1'b1), 8'hE0, "R7 third read any address");
    chk_busy(1'b1, "R5 busy while programming");
    repeat (250) @(negedge clk);
    chk_busy(1'b0, "R5 busy released");
    rd(10'h021, 8'hA5, 8'hFF, "R5 R6 R10 true data after programming");
    rd(10'h021, 8'hA5, 8'hFF, "R7 no toggling after completion");
    rd(10'h022, 8'hFF, 8'hFF, "R8 write during programming ignored");

    // Full 32-byte page plus a foreign-page write
    for (int i = 0; i < 32; i++) begin
      wr(AW'(10'h040 + i), pg_val(i), 1'b1);
      if (i == 15) wr(10'h060, 8'h77, 1'b1);
    end
    repeat (300) @(negedge clk);
    for (int i = 0; i < 32; i++) rd(AW'(10'h040 + i), pg_val(i), 8'hFF, "R3 page byte");
    rd(10'h060, 8'hFF, 8'hFF, "R3 other-page write ignored");

    // Window kept open by a late byte, then expiry
    wr(10'h080, 8'h12, 1'b1);
    repeat (20) @(negedge clk);
    wr(10'h081, 8'h34, 1'b1);
    repeat (60) @(negedge clk);
    chk_busy(1'b1, "R4 window expired into programming");
    wr(10'h082, 8'h56, 1'b1);
    repeat (300) @(negedge clk);
    rd(10'h080, 8'h12, 8'hFF, "R4 first byte");
    rd(10'h081, 8'h34, 8'hFF, "R4 byte inside window");
    rd(10'h082, 8'hFF, 8'hFF, "R4 byte after expiry ignored");

    // Capture points of address and data
    wr_shift(10'h0A0, 8'hC3, 10'h0A1, 8'h5E);
    rd(10'h0A0, stat(8'h5E, 1'b0, 1'b0), 8'hE0, "R2 R6 status uses final data");
    repeat (300) @(negedge clk);
    rd(10'h0A0, 8'h5E, 8'hFF, "R2 data taken at end, address at start");
    rd(10'h0A1, 8'hFF, 8'hFF, "R2 late address unused");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule